// File: doc/BRIEF.md
# DMA Command Queue Register Stub

This block is the register face of a host-to-memory DMA engine's command queue. It moves no data. Software sees a 4 KiB window of 32-bit registers: a queue base address, an end pointer, a write pointer, a read pointer, an interrupt enable word and an interrupt status word. Every other word in the register area is plain storage. A write to the write pointer stands in for the whole transfer. The engine finishes at once: the read pointer catches up with the write pointer and both completion flags go up.

Software can hold back one completion. It writes a fixed key value to the read pointer, and the next write-pointer update then advances the pointers without raising the flags. The block drives one registered, level-sensitive interrupt. Requests use a single-cycle valid strobe with byte strobes. Every request is accepted in the cycle it is presented. Read data comes back one cycle later with its own valid flag.

Top module: `dmaq_regstub`

## Requirements
- R1: After reset, every register reads zero except interrupt status, which reads 0xF8000000. The interrupt output is low and the completion key is not armed.
- R2: A write to the end pointer (offset 0x14) stores only the low 18 bits of the data (mask 0x0003FFFF).
- R3: A write to the write pointer (offset 0x18) stores the low 18 bits. The read pointer (offset 0x1C) then reads the same masked value.
- R4: A write-pointer write with the key not armed sets status bits 4 and 5. On the same edge the interrupt output goes high if enable bit 4 or bit 5 is set. If neither enable bit is set, the interrupt stays low.
- R5: Writing 0xEE882266 to the read pointer arms the key. The next write-pointer write still updates both pointers, but it sets no status bit, leaves the interrupt unchanged and disarms the key. The write after that completes normally.
- R6: A read-pointer write of any other value changes neither the read pointer nor the key. A key write does not change the read pointer either.
- R7: A write to interrupt enable (offset 0x20) stores the data ANDed with 0xBFEFF07F.
- R8: A write to interrupt status (offset 0x24) with bit 4 or bit 5 set clears both bits and drives the interrupt low. Any status write leaves all other status bits as they were. A status write with neither bit set changes nothing.
- R9: Any other word below byte offset 0x80, including the queue base at 0x10, stores and returns all 32 bits.
- R10: Reads at offsets 0x80 to 0xFFF return zero. Writes there are dropped and do not alias onto the register area.
- R11: A write whose byte strobes are not all ones changes nothing.
- R12: Address bits 1:0 are ignored, so an unaligned offset accesses the word that contains it.
- R13: Read data and a one-cycle response valid appear on the cycle after the read is accepted. Writes produce no response. The interrupt output changes only on the edge that accepts a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; accepted in the same cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte strobes; writes need all four set |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Registered level interrupt |

## Verification
Most internal state shows up quickly at the ports. A wrong pointer mask or a missed read-pointer copy shows in the first read after the write, two cycles after the write request. A key that stays armed or is lost shows in the status read-back and the interrupt level just after the next write-pointer update. An interrupt register that drifts from the enable and status words shows on the edge that accepts the completion or the clear. Aliasing beyond the register area shows only when the shadowed word is read back, so the tests read those words after every stray write.

// File: rtl/dmaq_pkg.sv
// Shared constants for the DMA command queue register stub.
// Assumes a 32-bit data path; the word indices are the byte offsets divided by four.
package dmaq_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned IX_QBASE  = 4;   // 0x10 queue base (plain storage)
    localparam int unsigned IX_QEND   = 5;   // 0x14 end pointer
    localparam int unsigned IX_QWR    = 6;   // 0x18 write pointer
    localparam int unsigned IX_QRD    = 7;   // 0x1C read pointer
    localparam int unsigned IX_IEN    = 8;   // 0x20 interrupt enable
    localparam int unsigned IX_IST    = 9;   // 0x24 interrupt status
    localparam logic [WORD_W-1:0] PTR_MASK  = 32'h0003_FFFF;
    localparam logic [WORD_W-1:0] IEN_MASK  = 32'hBFEF_F07F;
    localparam logic [WORD_W-1:0] IST_RESET = 32'hF800_0000;
    localparam logic [WORD_W-1:0] ARM_KEY   = 32'hEE88_2266;
    localparam logic [WORD_W-1:0] DONE_BITS = 32'h0000_0030;
endpackage

// File: rtl/dmaq_bus_decode.sv
// Request decoder: turns a byte offset into a word index and qualifies
// reads and writes. Assumes REG_WORDS covers at least the ten named words.
// Writes need all byte strobes set and an offset inside the register area.
module dmaq_bus_decode #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned REG_WORDS = 32,
    localparam int unsigned IDX_W    = $clog2(REG_WORDS),
    localparam int unsigned WA_W     = ADDR_W - 2
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_wstrb,
    output logic              wr_en_o,
    output logic              rd_en_o,
    output logic              in_area_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [WA_W-1:0] word_addr;
    logic            unused_lsb;

    // Drop the byte lane bits; accesses are whole words.
    always_comb begin
        word_addr  = req_addr[ADDR_W-1:2];
        unused_lsb = ^req_addr[1:0];
        in_area_o  = (word_addr < WA_W'(REG_WORDS));
        idx_o      = word_addr[IDX_W-1:0];
        wr_en_o    = req_valid && req_write && (req_wstrb == 4'hF) && in_area_o;
        rd_en_o    = req_valid && !req_write;
    end
endmodule

// File: rtl/dmaq_queue_regs.sv
// Queue pointer registers: end, write and read pointers plus the one-shot
// completion key. Emits a completion pulse when a write-pointer update is
// not held back by the key. Assumes at most one write per cycle.
module dmaq_queue_regs #(
    parameter int unsigned REG_WORDS = 32,
    localparam int unsigned IDX_W    = $clog2(REG_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [dmaq_pkg::WORD_W-1:0] wdata_i,
    output logic [dmaq_pkg::WORD_W-1:0] end_ptr_o,
    output logic [dmaq_pkg::WORD_W-1:0] wr_ptr_o,
    output logic [dmaq_pkg::WORD_W-1:0] rd_ptr_o,
    output logic                        cmpl_o
);
    import dmaq_pkg::*;

    logic armed_q;
    logic hit_end, hit_wr, hit_rd, key_seen;

    // Per-register write hits and key detection.
    always_comb begin
        hit_end  = wr_en_i && (idx_i == IDX_W'(IX_QEND));
        hit_wr   = wr_en_i && (idx_i == IDX_W'(IX_QWR));
        hit_rd   = wr_en_i && (idx_i == IDX_W'(IX_QRD));
        key_seen = hit_rd && (wdata_i == ARM_KEY);
        cmpl_o   = hit_wr && !armed_q;
    end

    // Pointer storage; the write pointer also drags the read pointer along.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_ptr_o <= '0;
            wr_ptr_o  <= '0;
            rd_ptr_o  <= '0;
        end else begin
            if (hit_end) end_ptr_o <= wdata_i & PTR_MASK;
            if (hit_wr) begin
                wr_ptr_o <= wdata_i & PTR_MASK;
                rd_ptr_o <= wdata_i & PTR_MASK;
            end
        end
    end

    // One-shot key: armed by the key value, consumed by the next write-pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed_q <= 1'b0;
        else if (key_seen) armed_q <= 1'b1;
        else if (hit_wr)   armed_q <= 1'b0;
    end

    a_r3_rd_follows_wr: assert property (@(posedge clk) disable iff (!rst_n)
        hit_wr |=> (rd_ptr_o == wr_ptr_o));
    a_r5_key_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && armed_q) |=> !armed_q);
    a_r6_other_value_keeps_key: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rd && !key_seen) |=> (armed_q == $past(armed_q)) && $stable(rd_ptr_o));
endmodule

// File: rtl/dmaq_irq_regs.sv
// Interrupt enable and status registers and the registered interrupt level.
// A completion pulse sets both done bits and raises the line if enabled.
// A status write with a done bit set clears both and drops the line.
module dmaq_irq_regs #(
    parameter int unsigned REG_WORDS = 32,
    localparam int unsigned IDX_W    = $clog2(REG_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [dmaq_pkg::WORD_W-1:0] wdata_i,
    input  logic                        cmpl_i,
    output logic [dmaq_pkg::WORD_W-1:0] ien_o,
    output logic [dmaq_pkg::WORD_W-1:0] ist_o,
    output logic                        irq_o
);
    import dmaq_pkg::*;

    logic hit_ien, clr_done, en_any;

    // Decode enable writes and done-bit clears.
    always_comb begin
        hit_ien  = wr_en_i && (idx_i == IDX_W'(IX_IEN));
        clr_done = wr_en_i && (idx_i == IDX_W'(IX_IST)) && ((wdata_i & DONE_BITS) != '0);
        en_any   = (ien_o & DONE_BITS) != '0;
    end

    // Enable register with its writable-bit mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       ien_o <= '0;
        else if (hit_ien) ien_o <= wdata_i & IEN_MASK;
    end

    // Status register: set by completion, cleared by a done-bit write.
    always_ff @(posedge clk) begin
        if (!rst_n)        ist_o <= IST_RESET;
        else if (cmpl_i)   ist_o <= ist_o | DONE_BITS;
        else if (clr_done) ist_o <= ist_o & ~DONE_BITS;
    end

    // Interrupt level, moved only by completion or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 irq_o <= 1'b0;
        else if (cmpl_i && en_any)  irq_o <= 1'b1;
        else if (clr_done)          irq_o <= 1'b0;
    end

    a_r4_irq_on_enabled_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_i && en_any) |=> irq_o);
    a_r8_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        clr_done |=> (!irq_o && ((ist_o & DONE_BITS) == '0)));
    a_r8_upper_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(ist_o[31:6]) && $stable(ist_o[3:0]));
    a_r13_irq_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(irq_o));
endmodule

// File: rtl/dmaq_word_store.sv
// Plain storage for every register-area word that has no special meaning.
// The named queue and interrupt words are tied to zero here; their owners
// supply their values to the read path.
module dmaq_word_store #(
    parameter int unsigned REG_WORDS = 32,
    localparam int unsigned IDX_W    = $clog2(REG_WORDS)
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         wr_en_i,
    input  logic [IDX_W-1:0]                             idx_i,
    input  logic [dmaq_pkg::WORD_W-1:0]                  wdata_i,
    output logic [REG_WORDS-1:0][dmaq_pkg::WORD_W-1:0]   words_o
);
    import dmaq_pkg::*;

    for (genvar g = 0; g < REG_WORDS; g++) begin : g_word
        if (g >= IX_QEND && g <= IX_IST) begin : g_owned
            assign words_o[g] = '0;
        end else begin : g_plain
            // Full-width storage word.
            always_ff @(posedge clk) begin
                if (!rst_n)                                   words_o[g] <= '0;
                else if (wr_en_i && idx_i == IDX_W'(g))       words_o[g] <= wdata_i;
            end
        end
    end
endmodule

// File: rtl/dmaq_regstub.sv
// Top of the DMA command queue register stub. Decodes requests, hands
// writes to the queue, interrupt and storage blocks, and returns read data
// one cycle after each read. Every request is accepted in its own cycle.
module dmaq_regstub #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned REG_WORDS = 32,
    localparam int unsigned IDX_W    = $clog2(REG_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_wstrb,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              irq
);
    import dmaq_pkg::*;

    logic             wr_en, rd_en, in_area, cmpl;
    logic [IDX_W-1:0] idx;
    logic [WORD_W-1:0] end_ptr, wr_ptr, rd_ptr, ien, ist, rd_mux;
    logic [REG_WORDS-1:0][WORD_W-1:0] words;

    dmaq_bus_decode #(.ADDR_W(ADDR_W), .REG_WORDS(REG_WORDS)) decode_i (
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wstrb(req_wstrb), .wr_en_o(wr_en), .rd_en_o(rd_en),
        .in_area_o(in_area), .idx_o(idx));

    dmaq_queue_regs #(.REG_WORDS(REG_WORDS)) queue_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx), .wdata_i(req_wdata),
        .end_ptr_o(end_ptr), .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .cmpl_o(cmpl));

    dmaq_irq_regs #(.REG_WORDS(REG_WORDS)) irq_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx), .wdata_i(req_wdata),
        .cmpl_i(cmpl), .ien_o(ien), .ist_o(ist), .irq_o(irq));

    dmaq_word_store #(.REG_WORDS(REG_WORDS)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx), .wdata_i(req_wdata),
        .words_o(words));

    // Select the read source; outside the register area reads return zero.
    always_comb begin
        if (!in_area)                        rd_mux = '0;
        else if (idx == IDX_W'(IX_QEND))     rd_mux = end_ptr;
        else if (idx == IDX_W'(IX_QWR))      rd_mux = wr_ptr;
        else if (idx == IDX_W'(IX_QRD))      rd_mux = rd_ptr;
        else if (idx == IDX_W'(IX_IEN))      rd_mux = ien;
        else if (idx == IDX_W'(IX_IST))      rd_mux = ist;
        else                                 rd_mux = words[idx];
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) rsp_rdata <= rd_mux;
        end
    end

    a_r13_read_response: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    a_r13_no_response_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);
    a_r10_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !in_area) |=> (rsp_rdata == '0));
endmodule

// File: tb/dmaq_regstub_tb_top.sv
// Directed bench for the DMA command queue register stub.
module dmaq_regstub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_wstrb = 4'hF;
    logic        rsp_valid, irq;
    logic [31:0] rsp_rdata;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dmaq_regstub dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_wstrb(req_wstrb), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq));

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] s = 4'hF);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_wstrb = s;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wstrb = 4'hF;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic rchk(string req, logic [11:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rchk("R1 status", 12'h024, 32'hF800_0000);
        rchk("R1 endptr", 12'h014, 0);
        rchk("R1 rdptr", 12'h01C, 0);
        rchk("R1 enable", 12'h020, 0);
        rchk("R1 store", 12'h000, 0);
    endtask

    task automatic t_pointers();
        wr(12'h014, 32'hFFFF_FFFF);
        rchk("R2 endptr mask", 12'h014, 32'h0003_FFFF);
        wr(12'h018, 32'h1234_5678);
        chk("R4 irq stays low when disabled", {31'b0, irq}, 0);
        rchk("R3 wrptr mask", 12'h018, 32'h0000_5678);
        rchk("R3 rdptr copy", 12'h01C, 32'h0000_5678);
        rchk("R4 done bits set", 12'h024, 32'hF800_0030);
    endtask

    task automatic t_status_clear();
        wr(12'h024, 32'hFFFF_FFCF);
        rchk("R8 no done bit no effect", 12'h024, 32'hF800_0030);
        wr(12'h024, 32'h0000_0010);
        rchk("R8 both cleared", 12'h024, 32'hF800_0000);
    endtask

    task automatic t_enable();
        wr(12'h020, 32'hFFFF_FFFF);
        rchk("R7 enable mask", 12'h020, 32'hBFEF_F07F);
        wr(12'h020, 32'h0000_0010);
        wr(12'h018, 32'h0000_0001);
        chk("R4 irq raised", {31'b0, irq}, 1);
        wr(12'h024, 32'h0000_0020);
        chk("R8 irq dropped", {31'b0, irq}, 0);
        rchk("R8 status after clear", 12'h024, 32'hF800_0000);
    endtask

    task automatic t_key();
        wr(12'h020, 32'h0000_0030);
        wr(12'h01C, 32'hEE88_2266);
        rchk("R6 key leaves rdptr", 12'h01C, 32'h0000_0001);
        wr(12'h018, 32'h0000_0100);
        chk("R5 suppressed irq", {31'b0, irq}, 0);
        rchk("R5 suppressed status", 12'h024, 32'hF800_0000);
        rchk("R5 pointers still move", 12'h01C, 32'h0000_0100);
        wr(12'h018, 32'h0000_0200);
        chk("R5 next completes irq", {31'b0, irq}, 1);
        rchk("R5 next completes status", 12'h024, 32'hF800_0030);
        wr(12'h024, 32'h0000_0030);
        wr(12'h01C, 32'h0000_1234);
        rchk("R6 other value ignored", 12'h01C, 32'h0000_0200);
        wr(12'h018, 32'h0000_0300);
        chk("R6 key not armed", {31'b0, irq}, 1);
        wr(12'h024, 32'h0000_0010);
    endtask

    task automatic t_storage();
        wr(12'h010, 32'hDEAD_BEEF);
        rchk("R9 queue base", 12'h010, 32'hDEAD_BEEF);
        wr(12'h07C, 32'h1357_9BDF);
        rchk("R9 last word", 12'h07C, 32'h1357_9BDF);
        wr(12'h090, 32'hAAAA_5555);
        rchk("R10 outside reads zero", 12'h090, 0);
        rchk("R10 no alias", 12'h010, 32'hDEAD_BEEF);
        rchk("R10 top of window", 12'hFFC, 0);
        wr(12'h010, 32'h0000_0000, 4'h7);
        rchk("R11 partial strobe dropped", 12'h010, 32'hDEAD_BEEF);
        wr(12'h02B, 32'h0000_5A5A);
        rchk("R12 unaligned write", 12'h028, 32'h0000_5A5A);
        rchk("R12 unaligned read", 12'h029, 32'h0000_5A5A);
    endtask

    task automatic t_latency();
        logic [31:0] d;
        wr(12'h000, 32'h0000_00AB);
        chk("R13 no response to write", {31'b0, rsp_valid}, 0);
        rd(12'h000, d);
        chk("R13 response valid", {31'b0, rsp_valid}, 1);
        chk("R13 response data", d, 32'h0000_00AB);
        @(negedge clk);
        chk("R13 single-cycle valid", {31'b0, rsp_valid}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pointers();
        t_status_clear();
        t_enable();
        t_key();
        t_storage();
        t_latency();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule